// File: doc/BRIEF.md
# System clock prescaler and selector

This block makes the core's timing strobes in a single fast reference-clock domain. Three oscillator sources reach it as one-cycle tick enables: an on-chip internal oscillator, a high-speed main oscillator and a low-speed sub-clock oscillator. A 4-bit mode word picks one source and a prescale ratio of 1, 2, 4 or 8. The prescaler gives one system-clock strobe for every N ticks of the chosen source. A fixed divide-by-3 stage then turns every third system strobe into an instruction-clock strobe. One instruction-clock period is one machine cycle.

Software writes the mode word through a simple write-enable port and can read the last written value back at once. The new setting does not govern the strobes straight away. It waits for the next system strobe, so the old period always finishes in full. At that boundary both counters start again from zero. The source code 11 is reserved. A write that carries it keeps the previous source, takes the new prescale field and raises a sticky error flag. Reset selects the internal oscillator divided by 8.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset the readback is 4'b1100 (internal oscillator, divide by 8) and the error flag is 0. The first system strobe falls on the 8th internal tick sampled after reset is released.
- R2: Mode bits [1:0] pick the counted source: 00 internal (`src_int_tick`), 01 high-speed (`src_hs_tick`), 10 low-speed (`src_ls_tick`). Ticks of the sources that are not selected have no effect on the strobes.
- R3: Mode bits [3:2] set the ratio N: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. `sys_stb` pulses for one cycle, in the same cycle as every Nth selected tick.
- R4: `instr_stb` pulses in the same cycle as every third `sys_stb`, counted from the strobe at which a mode took effect, and at no other time.
- R5: A write whose bits [1:0] are 11 leaves the source field unchanged and takes bits [3:2] as the new prescale. It sets `mode_err`, which stays at 1 until reset, including across later legal writes.
- R6: In the cycle after a write, `mode_rdata` shows the accepted mode word.
- R7: A written mode takes effect at the next `sys_stb`. Until then the old source and ratio govern. After that strobe both the prescale and divide-by-3 counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_int_tick | input | 1 | Tick enable of the internal oscillator |
| src_hs_tick | input | 1 | Tick enable of the high-speed oscillator |
| src_ls_tick | input | 1 | Tick enable of the low-speed oscillator |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 4 | Mode word to write: [3:2] prescale, [1:0] source |
| mode_rdata | output | 4 | Last accepted mode word |
| sys_stb | output | 1 | System-clock strobe |
| instr_stb | output | 1 | Instruction-clock (machine-cycle) strobe |
| mode_err | output | 1 | Sticky flag: a reserved source code was written |

## Verification
The three sources tick with periods of 3, 2 and 5 reference cycles. A strobe interval counted in ticks of one source therefore changes if the design follows another source. Mode changes cover every source and every ratio, including through mode on a source that ticks every other cycle, so each source/ratio pairing can be told apart. Each change is written just after a strobe. The bench counts the old source's ticks up to the next strobe, which separates immediate switching from switching at the boundary. It then counts the new source's ticks and the position of each instruction strobe, which shows whether the counters were restarted. Two reserved writes, one after a high-speed source and one after an internal source, show that the source field is kept and that the flag survives a later legal write.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
  localparam int SRC_W  = 2;
  localparam int PSC_W  = 2;
  localparam int MODE_W = SRC_W + PSC_W;
  localparam int NSRC   = 3;
  localparam int MAX_RATIO = 1 << ((1 << PSC_W) - 1);
  localparam int CNT_W  = $clog2(MAX_RATIO);

  typedef enum logic [SRC_W-1:0] {
    SRC_INT = 2'b00,
    SRC_HS  = 2'b01,
    SRC_LS  = 2'b10,
    SRC_RSV = 2'b11
  } src_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    src_e             src;
  } mode_t;

  localparam mode_t MODE_RST = '{psc: 2'b11, src: SRC_INT};

  // prescale field -> number of source ticks per system strobe
  function automatic int unsigned psc_ratio(input logic [PSC_W-1:0] p);
    return 32'd1 << p;
  endfunction

  function automatic logic src_reserved(input logic [SRC_W-1:0] s);
    return s == SRC_RSV;
  endfunction

  // apply a write: a reserved source code keeps the current source
  function automatic mode_t merge_write(input mode_t cur, input logic [MODE_W-1:0] wd);
    mode_t m;
    m = mode_t'(wd);
    if (src_reserved(wd[SRC_W-1:0])) m.src = cur.src;
    return m;
  endfunction

  function automatic logic pick_tick(input src_e s, input logic [NSRC-1:0] t);
    case (s)
      SRC_INT: return t[0];
      SRC_HS:  return t[1];
      SRC_LS:  return t[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/clkpre_mode_reg.sv
module clkpre_mode_reg
  import clkpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  input  logic              sys_stb,
  output mode_t             pend_q,
  output mode_t             active_q,
  output logic              err_q,
  output logic              apply
);
  mode_t wr_word;
  logic  wr_bad;
  logic  upd_q;

  assign wr_bad  = we && src_reserved(wdata[SRC_W-1:0]);
  assign wr_word = merge_write(pend_q, wdata);
  assign apply   = sys_stb && (upd_q || we);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= MODE_RST;
      active_q <= MODE_RST;
      upd_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (we) pend_q <= wr_word;
      if (sys_stb) upd_q <= 1'b0;
      else if (we) upd_q <= 1'b1;
      if (apply) active_q <= we ? wr_word : pend_q;
      if (wr_bad) err_q <= 1'b1;
    end
  end

  assert_src_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q.src != SRC_RSV) && (pend_q.src != SRC_RSV));
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_bad_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_q);
  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_bad) |=> (pend_q == mode_t'($past(wdata))));
  assert_hold_until_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_stb |=> $stable(active_q));
endmodule

// File: rtl/clkpre_prescale.sv
module clkpre_prescale
  import clkpre_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  mode_t           mode,
  input  logic [NSRC-1:0] ticks,
  output logic            tick_sel,
  output logic            sys_stb
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = CNT_W'(psc_ratio(mode.psc) - 1);
  assign tick_sel = pick_tick(mode.src, ticks);
  assign sys_stb  = tick_sel && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sys_stb)  cnt_q <= '0;
    else if (tick_sel) cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_sel |=> $stable(cnt_q));
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < psc_ratio(mode.psc));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_stb |=> (cnt_q == '0));
endmodule

// File: rtl/clkpre_div3.sv
module clkpre_div3 #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_stb,
  input  logic restart,
  output logic instr_stb
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign instr_stb = sys_stb && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart || instr_stb)  cnt_q <= '0;
    else if (sys_stb)               cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_stb && !restart && !instr_stb) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_stb |=> $stable(cnt_q));
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import clkpre_pkg::*;
#(
  parameter int INSTR_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_int_tick,
  input  logic              src_hs_tick,
  input  logic              src_ls_tick,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  output logic              sys_stb,
  output logic              instr_stb,
  output logic              mode_err
);
  mode_t           pend_mode;
  mode_t           act_mode;
  logic            apply_evt;
  logic            sel_tick;
  logic [NSRC-1:0] tick_vec;

  assign tick_vec = {src_ls_tick, src_hs_tick, src_int_tick};

  clkpre_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mode_we),
    .wdata    (mode_wdata),
    .sys_stb  (sys_stb),
    .pend_q   (pend_mode),
    .active_q (act_mode),
    .err_q    (mode_err),
    .apply    (apply_evt)
  );

  clkpre_prescale u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (act_mode),
    .ticks    (tick_vec),
    .tick_sel (sel_tick),
    .sys_stb  (sys_stb)
  );

  clkpre_div3 #(.DIV(INSTR_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_stb   (sys_stb),
    .restart   (apply_evt),
    .instr_stb (instr_stb)
  );

  assign mode_rdata = pend_mode;

  assert_stb_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_stb |-> sel_tick);
  assert_instr_with_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_stb |-> sys_stb);
  assert_apply_on_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |-> sys_stb);
endmodule

// File: tb/sim_sysclk_prescaler.sv
`timescale 1ns/1ps
module sim_sysclk_prescaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_int_tick = 1'b0, src_hs_tick = 1'b0, src_ls_tick = 1'b0;
  logic mode_we = 1'b0;
  logic [3:0] mode_wdata = 4'h0;
  logic [3:0] mode_rdata;
  logic sys_stb, instr_stb, mode_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sysclk_prescaler u0 (
    .clk(clk), .rst_n(rst_n),
    .src_int_tick(src_int_tick), .src_hs_tick(src_hs_tick), .src_ls_tick(src_ls_tick),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
    .sys_stb(sys_stb), .instr_stb(instr_stb), .mode_err(mode_err)
  );

  // source ticks: internal every 3, high-speed every 2, low-speed every 5 cycles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      src_int_tick = (cyc % 3 == 0);
      src_hs_tick  = (cyc % 2 == 0);
      src_ls_tick  = (cyc % 5 == 0);
    end
  end

  function automatic logic tick_of(input int src);
    case (src)
      0: return src_int_tick;
      1: return src_hs_tick;
      2: return src_ls_tick;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // R1: reset state and first strobe at the 8th internal tick
  task automatic test_reset();
    int cnt = 0;
    int guard = 0;
    bit seen = 1'b0;
    bit early_instr = 1'b0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    chk(mode_rdata == 4'b1100, "R1", "reset readback", mode_rdata, 4'b1100);
    chk(mode_err == 1'b0, "R1", "reset error flag", mode_err, 0);
    while (!seen && guard < 200) begin
      if (tick_of(0)) cnt++;
      if (instr_stb) early_instr = 1'b1;
      if (sys_stb) seen = 1'b1;
      else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(seen && cnt == 8, "R1", "internal ticks to first strobe", cnt, 8);
    chk(!early_instr, "R1", "instr strobe on first system strobe", early_instr, 0);
  endtask

  // write a mode just after a strobe, check the boundary, readback, then the new timing
  task automatic test_switch(input string name, input int old_src, input int old_n,
                             input logic [3:0] wword, input logic [3:0] exp_rd,
                             input bit exp_err, input int new_src, input int new_n,
                             input int nstb);
    int guard = 0;
    int cnt = 0;
    int k = 0;
    int bad_ticks = 0;
    int bad_instr = 0;
    int idx = 0;
    bit hit = 1'b0;
    // align to a strobe under the old mode
    while (!sys_stb && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    // phase A: the write and the rest of the old period
    while (!hit && idx < 400) begin
      @(posedge clk);
      #2;
      mode_we    = (idx == 0);
      mode_wdata = wword;
      @(negedge clk);
      if (idx == 1) begin
        chk(mode_rdata == exp_rd, "R6", {name, " readback"}, mode_rdata, exp_rd);
        chk(mode_err == exp_err, "R5", {name, " error flag"}, mode_err, exp_err);
      end
      if (tick_of(old_src)) cnt++;
      if (sys_stb) hit = 1'b1;
      idx++;
    end
    chk(hit && cnt == old_n, "R7", {name, " old ticks to switching strobe"}, cnt, old_n);
    // phase B: strobes under the new mode
    cnt = 0;
    guard = 0;
    while (k < nstb && guard < 2000) begin
      @(posedge clk);
      #2;
      mode_we = 1'b0;
      @(negedge clk);
      guard++;
      if (tick_of(new_src)) cnt++;
      if (sys_stb) begin
        k++;
        if (!tick_of(new_src) || cnt != new_n) bad_ticks++;
        if (instr_stb != (k % 3 == 0)) bad_instr++;
        cnt = 0;
      end else if (instr_stb) begin
        bad_instr++;
      end
    end
    chk(k == nstb && bad_ticks == 0, "R3",
        {name, " strobe intervals in selected ticks (R2 source)"}, bad_ticks, 0);
    chk(k == nstb && bad_instr == 0, "R4", {name, " instruction strobe positions"}, bad_instr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    test_reset();
    test_switch("int8->hs2", 0, 8, 4'b0101, 4'b0101, 1'b0, 1, 2, 9);
    test_switch("hs2->ls4", 1, 2, 4'b1010, 4'b1010, 1'b0, 2, 4, 6);
    test_switch("ls4->hs1", 2, 4, 4'b0001, 4'b0001, 1'b0, 1, 1, 9);
    // R5: reserved source code keeps high-speed, prescale becomes 4
    test_switch("reserved after hs", 1, 1, 4'b1011, 4'b1001, 1'b1, 1, 4, 6);
    // R5: legal write afterwards, flag stays set
    test_switch("hs4->int2", 1, 4, 4'b0100, 4'b0100, 1'b1, 0, 2, 6);
    // R5: reserved source code keeps internal, prescale becomes 8
    test_switch("reserved after int", 0, 2, 4'b1111, 4'b1100, 1'b1, 0, 8, 3);
    test_switch("int8->ls1", 0, 8, 4'b0010, 4'b0010, 1'b1, 2, 1, 6);
    finish_run();
  end
endmodule